// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block holds the one-bit output-compare state of a single timer channel and drives a port pin from it. The surrounding timer supplies event strobes: a compare match, a software force request and a counter-at-BOTTOM marker. It also supplies a counting-direction flag and a waveform-mode selector. A two-bit output mode field says how each event changes the stored state. The meaning of each mode value depends on whether the timer runs as a plain counter, in single-slope PWM or in dual-slope PWM.

The stored state is a two-state machine with the states `ST_LOW` and `ST_HIGH`. Each rising clock edge applies one of four decoded actions: hold, clear (go to `ST_LOW`), set (go to `ST_HIGH`) or toggle (go to the other state). The transitions are LOW→HIGH on set or toggle, HIGH→LOW on clear or toggle, and a self-loop on hold or on an action that already matches the current state. The pin side is purely combinational. Any nonzero output mode makes the compare state the pin's data source in place of the port data latch. The data-direction bit alone decides whether the pin is driven or left high impedance. This allows the compare state to be prepared while the pin is still an input.

Top module: `cmpout_unit`

## Requirements
- R1: While reset (`rst_ni` low) is asserted, the compare state is `ST_LOW`, so a pin observed with a nonzero mode and direction 1 reads 0.
- R2: With `out_mode_i` = 00, no event changes the compare state, in every waveform mode.
- R3: With `wave_sel_i` = 00 (plain counting), a match applies the mode's action at the next rising edge: 01 toggles, 10 clears, 11 sets.
- R4: With `wave_sel_i` = 00, `cmp_force_i` applies the same action as a match. A force and a match in the same cycle apply that action only once.
- R5: With `wave_sel_i` = 01 (single-slope PWM), a match clears the state under mode 10 and sets it under mode 11. `cnt_bottom_i` does the opposite: it sets under 10 and clears under 11. When both arrive in the same cycle, the match decides. Mode 01 changes nothing.
- R6: With `wave_sel_i` = 10 (dual-slope PWM), mode 10 clears the state on a match while counting up (`cnt_down_i` = 0) and sets it on a match while counting down. Mode 11 does the reverse. `cnt_bottom_i` and mode 01 change nothing.
- R7: `cmp_force_i` has no effect when `wave_sel_i` is 01 or 10. The reserved value `wave_sel_i` = 11 changes the state on no event.
- R8: `pin_o` equals the compare state when `out_mode_i` is nonzero, and equals `port_data_i` when it is 00.
- R9: `pin_oe_o` equals `port_dir_i` regardless of mode. The compare state updates while `pin_oe_o` is 0, and the updated value appears on the pin as soon as the direction becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock; state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_match_i | input | 1 | Compare-match strobe from the comparator |
| cmp_force_i | input | 1 | Software force-compare strobe |
| cnt_bottom_i | input | 1 | Counter-at-BOTTOM strobe |
| cnt_down_i | input | 1 | 1 while the counter counts down |
| out_mode_i | input | 2 | Compare output mode field |
| wave_sel_i | input | 2 | Waveform mode: 00 plain, 01 single-slope PWM, 10 dual-slope PWM, 11 reserved |
| port_data_i | input | 1 | Port data latch value |
| port_dir_i | input | 1 | Port direction latch (1 = output) |
| pin_o | output | 1 | Value presented to the pad |
| pin_oe_o | output | 1 | Pad output enable; 0 means high impedance |

## Verification
A wrong compare state is invisible while the mode is 00 or the direction is input. It appears on `pin_o` within the same cycle that a nonzero mode and output direction are selected, and it then persists until the next event rewrites it. The bench therefore places the state in a known value, applies one event combination and reads the result through the pin with a neutral configuration one clock later. Every waveform mode, output mode, starting state and strobe pattern is swept, so a decode error surfaces at the first edge after the faulty combination.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;

    localparam int MODE_W = 2;
    localparam int WAVE_W = 2;

    typedef enum logic [WAVE_W-1:0] {
        WG_PLAIN = 2'b00,
        WG_SLOPE = 2'b01,
        WG_DUAL  = 2'b10,
        WG_RSVD  = 2'b11
    } wave_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_CLEAR  = 2'b01,
        ACT_SET    = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } cmp_st_e;

    localparam logic [MODE_W-1:0] MD_OFF   = 2'b00;
    localparam logic [MODE_W-1:0] MD_TOGL  = 2'b01;
    localparam logic [MODE_W-1:0] MD_CLR   = 2'b10;
    localparam logic [MODE_W-1:0] MD_SET   = 2'b11;

endpackage

// File: rtl/cmpout_action_dec.sv
module cmpout_action_dec
    import cmpout_pkg::*;
(
    input  wave_e             wave_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              match_i,
    input  logic              force_i,
    input  logic              bottom_i,
    input  logic              down_i,
    output act_e              act_o
);

    always_comb begin
        act_o = ACT_HOLD;
        unique case (wave_i)
            WG_PLAIN: begin
                if (match_i || force_i) begin
                    unique case (mode_i)
                        MD_TOGL: act_o = ACT_TOGGLE;
                        MD_CLR:  act_o = ACT_CLEAR;
                        MD_SET:  act_o = ACT_SET;
                        default: act_o = ACT_HOLD;
                    endcase
                end
            end
            WG_SLOPE: begin
                if (match_i) begin
                    unique case (mode_i)
                        MD_CLR:  act_o = ACT_CLEAR;
                        MD_SET:  act_o = ACT_SET;
                        default: act_o = ACT_HOLD;
                    endcase
                end else if (bottom_i) begin
                    unique case (mode_i)
                        MD_CLR:  act_o = ACT_SET;
                        MD_SET:  act_o = ACT_CLEAR;
                        default: act_o = ACT_HOLD;
                    endcase
                end
            end
            WG_DUAL: begin
                if (match_i) begin
                    unique case (mode_i)
                        MD_CLR:  act_o = down_i ? ACT_SET : ACT_CLEAR;
                        MD_SET:  act_o = down_i ? ACT_CLEAR : ACT_SET;
                        default: act_o = ACT_HOLD;
                    endcase
                end
            end
            default: act_o = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/cmpout_state_fsm.sv
module cmpout_state_fsm
    import cmpout_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  act_e act_i,
    output logic cmp_o
);

    cmp_st_e state_q;
    cmp_st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (act_i)
            ACT_CLEAR:  state_d = ST_LOW;
            ACT_SET:    state_d = ST_HIGH;
            ACT_TOGGLE: state_d = (state_q == ST_HIGH) ? ST_LOW : ST_HIGH;
            default:    state_d = state_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cmp_o = (state_q == ST_HIGH);
    end

    // R3
    toggle_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_i == ACT_TOGGLE) |=> (cmp_o != $past(cmp_o)));

    // R3
    clear_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_i == ACT_CLEAR) |=> !cmp_o);

    // R3
    set_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_i == ACT_SET) |=> cmp_o);

endmodule

// File: rtl/cmpout_pin_mux.sv
module cmpout_pin_mux
    import cmpout_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              cmp_i,
    input  logic              port_data_i,
    input  logic              port_dir_i,
    output logic              pin_o,
    output logic              pin_oe_o
);

    logic override;

    always_comb begin
        override = |mode_i;
        pin_o    = override ? cmp_i : port_data_i;
        pin_oe_o = port_dir_i;
    end

endmodule

// File: rtl/cmpout_unit.sv
module cmpout_unit
    import cmpout_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmp_match_i,
    input  logic              cmp_force_i,
    input  logic              cnt_bottom_i,
    input  logic              cnt_down_i,
    input  logic [MODE_W-1:0] out_mode_i,
    input  logic [WAVE_W-1:0] wave_sel_i,
    input  logic              port_data_i,
    input  logic              port_dir_i,
    output logic              pin_o,
    output logic              pin_oe_o
);

    wave_e wave;
    act_e  act;
    logic  cmp_q;

    always_comb begin
        wave = wave_e'(wave_sel_i);
    end

    cmpout_action_dec u_dec (
        .wave_i   (wave),
        .mode_i   (out_mode_i),
        .match_i  (cmp_match_i),
        .force_i  (cmp_force_i),
        .bottom_i (cnt_bottom_i),
        .down_i   (cnt_down_i),
        .act_o    (act)
    );

    cmpout_state_fsm u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .act_i  (act),
        .cmp_o  (cmp_q)
    );

    cmpout_pin_mux u_mux (
        .mode_i      (out_mode_i),
        .cmp_i       (cmp_q),
        .port_data_i (port_data_i),
        .port_dir_i  (port_dir_i),
        .pin_o       (pin_o),
        .pin_oe_o    (pin_oe_o)
    );

    // R2
    mode_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_mode_i == MD_OFF) |=> (cmp_q == $past(cmp_q)));

    // R7
    pwm_force_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((wave_sel_i != 2'b00) && cmp_force_i && !cmp_match_i && !cnt_bottom_i)
        |=> (cmp_q == $past(cmp_q)));

    // R7
    rsvd_wave_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wave_sel_i == 2'b11) |=> (cmp_q == $past(cmp_q)));

    // R6
    dual_up_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((wave_sel_i == 2'b10) && (out_mode_i == MD_CLR) && cmp_match_i && !cnt_down_i)
        |=> !cmp_q);

    // R8
    pin_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_mode_i != MD_OFF) |-> (pin_o == cmp_q));

endmodule

// File: tb/cmpout_unit_tb.sv
module cmpout_unit_tb;

    logic       clk;
    logic       rst_n;
    logic       match;
    logic       frc;
    logic       bot;
    logic       dn;
    logic [1:0] mode;
    logic [1:0] wave;
    logic       pdata;
    logic       pdir;
    logic       pin;
    logic       pin_oe;

    int n_run;
    int n_fail;
    bit done;

    cmpout_unit u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cmp_match_i  (match),
        .cmp_force_i  (frc),
        .cnt_bottom_i (bot),
        .cnt_down_i   (dn),
        .out_mode_i   (mode),
        .wave_sel_i   (wave),
        .port_data_i  (pdata),
        .port_dir_i   (pdir),
        .pin_o        (pin),
        .pin_oe_o     (pin_oe)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic drive(input logic [1:0] w, input logic [1:0] m, input logic mt,
                         input logic fc, input logic bt, input logic d,
                         input logic pd, input logic dir);
        wave = w; mode = m; match = mt; frc = fc; bot = bt; dn = d;
        pdata = pd; pdir = dir;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (wave=%b mode=%b)", req, act, exp, wave, mode);
        end
    endtask

    function automatic logic model(input int w, input int m, input logic s,
                                   input logic mt, input logic fc, input logic bt,
                                   input logic d);
        logic r;
        r = s;
        if (w == 0) begin
            if (mt || fc) begin
                if (m == 1) r = ~s;
                else if (m == 2) r = 1'b0;
                else if (m == 3) r = 1'b1;
            end
        end else if (w == 1) begin
            if (mt) begin
                if (m == 2) r = 1'b0;
                else if (m == 3) r = 1'b1;
            end else if (bt) begin
                if (m == 2) r = 1'b1;
                else if (m == 3) r = 1'b0;
            end
        end else if (w == 2) begin
            if (mt) begin
                if (m == 2) r = d;
                else if (m == 3) r = ~d;
            end
        end
        return r;
    endfunction

    // Put the state at s (plain mode, set or clear on match).
    task automatic preset(input logic s);
        @(negedge clk);
        drive(2'b00, s ? 2'b11 : 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    // Read state through the pin under a neutral configuration.
    task automatic observe(output logic v);
        @(negedge clk);
        drive(2'b11, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        #1 v = pin;
    endtask

    initial begin
        n_run = 0; n_fail = 0; done = 0;
        rst_n = 1'b0;
        drive(2'b11, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        // R1: reset state reads 0 through the pin
        #1 check("R1", pin, 1'b0);
        check("R1", pin_oe, 1'b1);
        rst_n = 1'b1;
        begin
            logic v;
            observe(v);
            check("R1", v, 1'b0);
        end

        // Event sweep: R2 R3 R4 R5 R6 R7
        for (int w = 0; w < 4; w++) begin
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int ev = 0; ev < 16; ev++) begin
                        logic v;
                        logic e;
                        string tag;
                        preset(s[0]);
                        @(negedge clk);
                        drive(w[1:0], m[1:0], ev[0], ev[1], ev[2], ev[3], 1'b0, 1'b0);
                        e = model(w, m, s[0], ev[0], ev[1], ev[2], ev[3]);
                        observe(v);
                        if (m == 0) tag = "R2";
                        else if (w == 3) tag = "R7";
                        else if (w == 0) tag = ev[1] ? "R4" : "R3";
                        else if (w == 1) tag = ev[1] && !ev[0] && !ev[2] ? "R7" : "R5";
                        else tag = ev[1] && !ev[0] ? "R7" : "R6";
                        check(tag, v, e);
                    end
                end
            end
        end

        // Pin mux sweep: R8 R9
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int pd = 0; pd < 2; pd++) begin
                    for (int dir = 0; dir < 2; dir++) begin
                        preset(s[0]);
                        @(negedge clk);
                        drive(2'b11, m[1:0], 1'b0, 1'b0, 1'b0, 1'b0, pd[0], dir[0]);
                        #1;
                        check("R8", pin, (m != 0) ? s[0] : pd[0]);
                        check("R9", pin_oe, dir[0]);
                    end
                end
            end
        end

        // R9: state prepared while pin is an input, then enabled
        @(negedge clk);
        drive(2'b00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        drive(2'b00, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        #1 check("R9", pin_oe, 1'b0);
        check("R9", pin, 1'b1);
        @(negedge clk);
        drive(2'b11, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        #1 check("R9", pin_oe, 1'b1);
        check("R9", pin, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule